// File: doc/BRIEF.md
# Bit-Serial SIMD Processing Array

The block is a row of identical one-bit processing elements that all execute the same instruction in the same clock cycle. Each element owns one bit column of a shared memory. A row address therefore selects one bit-plane that holds one bit for every element. Multi-bit values are stored vertically, one bit per row, and are processed one bit position at a time. Bit-serial addition is the heaviest operation the array is built for.

There are no fixed opcodes. An instruction carries two 8-entry truth tables, one for each accumulator. Each element forms a 3-bit index, looks up its new accumulator bits in the two tables, and can then:
- write a chosen accumulator back into a row;
- take a neighbour's accumulator bit;
- load a private enable bit that masks its memory writes.

A registered flag reports whether every element's first accumulator is zero.

Top module: `simd_array`

## Requirements
- R1: After reset, both accumulators are 0 in every element, every enable bit is 1 and `zero_o` is 1.
- R2: Operation class 00 (compute) replaces acc0 and acc1 in every element with `tt0_i[idx]` and `tt1_i[idx]`. Here idx = imm*4 + acc1*2 + acc0. The new values are visible at the outputs after the sampling edge.
- R3: Operation class 01 (read) fetches row `row_i`, one bit per element. It captures both tables. On the following edge it applies them with idx = membit*4 + acc1*2 + acc0. An instruction issued directly after a read already operates on the updated values.
- R4: Operation class 10 (write) stores one bit per element into row `row_i`. `sel_i[0]` picks the source: 0 for acc0, 1 for acc1. The accumulators are unchanged.
- R5: An element whose enable bit is 0 leaves its memory bit unchanged on a write.
- R6: A compute instruction with `sel_i[1]`=1 loads each enable bit from that element's new acc0. All other instructions leave the enable bits unchanged.
- R7: Operation class 11 (shift) replaces one accumulator and leaves the other unchanged. `sel_i[0]`=0 shifts acc0 and 1 shifts acc1. With `sel_i[1]`=0, element i takes element i-1's value; with `sel_i[1]`=1, it takes element i+1's value.
- R8: Shifts fill the vacated end element with 0 and never wrap around.
- R9: `zero_o` is 1 exactly when every bit of `acc0_o` is 0, in the same cycle.
- R10: An N-bit add (read X[i], read Y[i], write Z[i], least significant bit first) takes 3·N back-to-back instructions. Afterwards Z holds X+Y modulo 2^N and acc1 holds the carry out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 2 | Operation class: 00 compute, 01 read, 10 write, 11 shift |
| row_i | input | ROW_W | Bit-plane row address |
| tt0_i | input | 8 | Truth table for acc0 |
| tt1_i | input | 8 | Truth table for acc1 |
| imm_i | input | 1 | Immediate bit, used as the top index bit by compute |
| sel_i | input | 2 | Accumulator and direction select; bit 1 on compute loads the enable bits |
| acc0_o | output | NUM_PE | acc0 of every element |
| acc1_o | output | NUM_PE | acc1 of every element |
| zero_o | output | 1 | All acc0 bits are zero |

## Verification
Compute and shift results, and the zero flag, appear at the outputs right after the edge that samples the instruction. A read shows its table update one edge later. The scoreboard records the edge number at which each instruction was taken. Each expected item is queued with a delay of zero or one edge from that point, and the monitor compares it on the falling edge where that edge count is reached. After a read-back the bench lets the queue drain before it issues the next instruction, so later instructions never overlap a pending comparison. The add sequence runs back to back to test forwarding, and its length in edges is itself checked.

// File: rtl/simd_pkg.sv
package simd_pkg;
  typedef enum logic [1:0] {
    OP_IMM   = 2'b00,
    OP_READ  = 2'b01,
    OP_WRITE = 2'b10,
    OP_SHIFT = 2'b11
  } simd_op_e;
endpackage

// File: rtl/simd_bitplane_mem.sv
module simd_bitplane_mem #(
  parameter int WIDTH = 1024,
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             re,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [WIDTH-1:0] wmask,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  // registered read port, bit-masked write port
  always_ff @(posedge clk) begin
    if (re) rdata <= mem[addr];
    for (int i = 0; i < WIDTH; i++) begin
      if (we && wmask[i]) mem[addr][i] <= wdata[i];
    end
  end
endmodule

// File: rtl/simd_pe.sv
module simd_pe
  import simd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  simd_op_e   op_i,
  input  logic       pend_i,
  input  logic [7:0] pend_tt0_i,
  input  logic [7:0] pend_tt1_i,
  input  logic       mem_bit_i,
  input  logic [7:0] tt0_i,
  input  logic [7:0] tt1_i,
  input  logic       imm_i,
  input  logic [1:0] sel_i,
  input  logic       lo0_i,
  input  logic       lo1_i,
  input  logic       hi0_i,
  input  logic       hi1_i,
  output logic       base0_o,
  output logic       base1_o,
  output logic       nxt0_o,
  output logic       wbit_o,
  output logic       en_o,
  output logic       acc0_o,
  output logic       acc1_o
);
  logic acc0_q, acc1_q, en_q;
  logic base0, base1, nxt0, nxt1;

  always_comb begin
    // finish a pending read lookup first, so the current instruction sees it
    base0 = pend_i ? pend_tt0_i[{mem_bit_i, acc1_q, acc0_q}] : acc0_q;
    base1 = pend_i ? pend_tt1_i[{mem_bit_i, acc1_q, acc0_q}] : acc1_q;
    nxt0  = base0;
    nxt1  = base1;
    case (op_i)
      OP_IMM: begin
        nxt0 = tt0_i[{imm_i, base1, base0}];
        nxt1 = tt1_i[{imm_i, base1, base0}];
      end
      OP_SHIFT: begin
        if (sel_i[0]) nxt1 = sel_i[1] ? hi1_i : lo1_i;
        else          nxt0 = sel_i[1] ? hi0_i : lo0_i;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc0_q <= 1'b0;
      acc1_q <= 1'b0;
      en_q   <= 1'b1;
    end else begin
      acc0_q <= nxt0;
      acc1_q <= nxt1;
      if (op_i == OP_IMM && sel_i[1]) en_q <= nxt0;
    end
  end

  assign base0_o = base0;
  assign base1_o = base1;
  assign nxt0_o  = nxt0;
  assign wbit_o  = sel_i[0] ? base1 : base0;
  assign en_o    = en_q;
  assign acc0_o  = acc0_q;
  assign acc1_o  = acc1_q;

  // R2: compute result follows the broadcast table
  p_imm_eval_r2: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_IMM && !pend_i) |=> (acc0_q == $past(tt0_i[{imm_i, acc1_q, acc0_q}])));
  // R6: enable only moves on a compute with the load flag
  p_en_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !(op_i == OP_IMM && sel_i[1]) |=> $stable(en_q));
  // R3/R4: plain read or write with nothing pending keeps accumulators
  p_acc_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (!pend_i && (op_i == OP_READ || op_i == OP_WRITE)) |=>
      (acc0_q == $past(acc0_q) && acc1_q == $past(acc1_q)));
endmodule

// File: rtl/simd_array.sv
module simd_array
  import simd_pkg::*;
#(
  parameter int NUM_PE   = 1024,
  parameter int NUM_ROWS = 1024,
  parameter int ROW_W    = $clog2(NUM_ROWS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        op_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [7:0]        tt0_i,
  input  logic [7:0]        tt1_i,
  input  logic              imm_i,
  input  logic [1:0]        sel_i,
  output logic [NUM_PE-1:0] acc0_o,
  output logic [NUM_PE-1:0] acc1_o,
  output logic              zero_o
);
  simd_op_e op;
  assign op = simd_op_e'(op_i);

  logic              pend_q;
  logic [7:0]        ptt0_q, ptt1_q;
  logic              zero_q;
  logic [NUM_PE-1:0] base0_v, base1_v, nxt0_v, wbit_v, en_v, rdata_v;
  logic [NUM_PE+1:0] ext0, ext1;

  // zero-padded neighbour buses: no wrap at either end
  assign ext0 = {1'b0, base0_v, 1'b0};
  assign ext1 = {1'b0, base1_v, 1'b0};

  simd_bitplane_mem #(.WIDTH(NUM_PE), .DEPTH(NUM_ROWS), .AW(ROW_W)) u_mem (
    .clk   (clk),
    .re    (op == OP_READ),
    .we    (op == OP_WRITE),
    .addr  (row_i),
    .wdata (wbit_v),
    .wmask (en_v),
    .rdata (rdata_v)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      ptt0_q <= '0;
      ptt1_q <= '0;
      zero_q <= 1'b1;
    end else begin
      pend_q <= (op == OP_READ);
      if (op == OP_READ) begin
        ptt0_q <= tt0_i;
        ptt1_q <= tt1_i;
      end
      zero_q <= ~|nxt0_v;
    end
  end

  for (genvar g = 0; g < NUM_PE; g++) begin : g_pe
    simd_pe u_pe (
      .clk        (clk),
      .rst        (rst),
      .op_i       (op),
      .pend_i     (pend_q),
      .pend_tt0_i (ptt0_q),
      .pend_tt1_i (ptt1_q),
      .mem_bit_i  (rdata_v[g]),
      .tt0_i      (tt0_i),
      .tt1_i      (tt1_i),
      .imm_i      (imm_i),
      .sel_i      (sel_i),
      .lo0_i      (ext0[g]),
      .lo1_i      (ext1[g]),
      .hi0_i      (ext0[g+2]),
      .hi1_i      (ext1[g+2]),
      .base0_o    (base0_v[g]),
      .base1_o    (base1_v[g]),
      .nxt0_o     (nxt0_v[g]),
      .wbit_o     (wbit_v[g]),
      .en_o       (en_v[g]),
      .acc0_o     (acc0_o[g]),
      .acc1_o     (acc1_o[g])
    );
  end

  assign zero_o = zero_q;

  // R8: vacated end element receives zero
  p_fill_low_r8: assert property (@(posedge clk) disable iff (rst)
    (op == OP_SHIFT && sel_i == 2'b00) |=> (acc0_o[0] == 1'b0));
  p_fill_high_r8: assert property (@(posedge clk) disable iff (rst)
    (op == OP_SHIFT && sel_i == 2'b10) |=> (acc0_o[NUM_PE-1] == 1'b0));
  // R9: reduction flag tracks acc0
  p_zero_flag_r9: assert property (@(posedge clk) disable iff (rst)
    zero_o == (acc0_o == '0));
endmodule

// File: tb/simd_array_test.sv
`timescale 1ns/1ps
module simd_array_test;
  localparam int NP = 8;
  localparam int NR = 16;
  localparam int RW = 4;
  localparam int NB = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [1:0]    op;
  logic [RW-1:0] row;
  logic [7:0]    tt0, tt1;
  logic          imm;
  logic [1:0]    sel;
  wire [NP-1:0]  acc0, acc1;
  wire           zero;

  simd_array #(.NUM_PE(NP), .NUM_ROWS(NR), .ROW_W(RW)) uut (
    .clk(clk), .rst(rst), .op_i(op), .row_i(row), .tt0_i(tt0), .tt1_i(tt1),
    .imm_i(imm), .sel_i(sel), .acc0_o(acc0), .acc1_o(acc1), .zero_o(zero)
  );

  int edges = 0;
  always @(posedge clk) edges <= edges + 1;

  int last_edge = 0;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  int            q_due[$];
  logic [NP-1:0] q_a0[$];
  logic [NP-1:0] q_a1[$];
  string         q_tag[$];

  task automatic set_idle();
    op = 2'b00; row = '0; tt0 = 8'hAA; tt1 = 8'hCC; imm = 1'b0; sel = 2'b00;
  endtask

  task automatic issue(input logic [1:0] o, input int r, input logic [7:0] t0,
                       input logic [7:0] t1, input logic im, input logic [1:0] s);
    @(negedge clk);
    op = o; row = r[RW-1:0]; tt0 = t0; tt1 = t1; imm = im; sel = s;
    @(posedge clk);
    #1;
    last_edge = edges;
    set_idle();
  endtask

  task automatic expect_at(input int dly, input logic [NP-1:0] a0,
                           input logic [NP-1:0] a1, input string tag);
    q_due.push_back(last_edge + dly);
    q_a0.push_back(a0);
    q_a1.push_back(a1);
    q_tag.push_back(tag);
  endtask

  task automatic drain();
    while (q_due.size() > 0) @(posedge clk);
    #1;
  endtask

  // monitor: compare queued items on the falling edge they fall due
  always @(negedge clk) begin
    while (q_due.size() > 0 && q_due[0] <= edges) begin
      n_chk++;
      if (q_due[0] != edges) begin
        n_bad++;
        $display("FAIL %s: check missed, actual edge %0d expected edge %0d",
                 q_tag[0], edges, q_due[0]);
      end else if (acc0 !== q_a0[0] || acc1 !== q_a1[0] || zero !== (q_a0[0] == '0)) begin
        n_bad++;
        $display("FAIL %s: actual acc0=%h acc1=%h zero=%b expected acc0=%h acc1=%h zero=%b",
                 q_tag[0], acc0, acc1, zero, q_a0[0], q_a1[0], (q_a0[0] == '0));
      end
      void'(q_due.pop_front()); void'(q_a0.pop_front());
      void'(q_a1.pop_front());  void'(q_tag.pop_front());
    end
  end

  // acc1 := one-hot at element 0, built with shifts from the upper neighbour
  task automatic make_marker();
    issue(2'b00, 0, 8'hAA, 8'hFF, 1'b0, 2'b00);
    for (int k = 0; k < NP - 1; k++) issue(2'b11, 0, 8'hAA, 8'hCC, 1'b0, 2'b11);
  endtask

  // shift a vector into acc0 bit by bit, then write it to row r
  task automatic load_row(input int r, input logic [NP-1:0] v);
    issue(2'b00, 0, 8'h00, 8'hCC, 1'b0, 2'b00);
    for (int k = NP - 1; k >= 0; k--) begin
      if (k != NP - 1) issue(2'b11, 0, 8'hAA, 8'hCC, 1'b0, 2'b00);
      issue(2'b00, 0, v[k] ? 8'hEE : 8'hAA, 8'hCC, 1'b0, 2'b00);
    end
    issue(2'b10, r, 8'hAA, 8'hCC, 1'b0, 2'b00);
  endtask

  logic [NB-1:0] xs [NP];
  logic [NB-1:0] ys [NP];
  logic [NP-1:0] xr [NB];
  logic [NP-1:0] yr [NB];
  logic [NP-1:0] zr [NB];
  logic [NP-1:0] cout;
  int start_edge;

  initial begin
    set_idle();
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(posedge clk); #1;
    last_edge = edges;
    expect_at(0, '0, '0, "R1 reset state");
    drain();

    // R2: compute with immediate in the index
    issue(2'b00, 0, 8'hF0, 8'hCC, 1'b1, 2'b00);
    expect_at(0, 8'hFF, 8'h00, "R2 imm=1 table F0, R9 flag low");
    issue(2'b00, 0, 8'hF0, 8'hCC, 1'b0, 2'b00);
    expect_at(0, 8'h00, 8'h00, "R2 imm=0 table F0, R9 flag high");
    drain();

    // R8: edge fill, no wrap
    issue(2'b00, 0, 8'hFF, 8'hCC, 1'b0, 2'b00);
    issue(2'b11, 0, 8'hAA, 8'hCC, 1'b0, 2'b00);
    expect_at(0, 8'hFE, 8'h00, "R8 low end fill");
    issue(2'b11, 0, 8'hAA, 8'hCC, 1'b0, 2'b10);
    expect_at(0, 8'h7F, 8'h00, "R8 high end fill");
    drain();

    // R3/R4: write rows and read them back
    make_marker();
    load_row(1, 8'hB5);
    load_row(2, 8'h3C);
    issue(2'b01, 1, 8'hF0, 8'hCC, 1'b0, 2'b00);
    expect_at(1, 8'hB5, 8'h01, "R3 read row 1");
    drain();
    issue(2'b01, 2, 8'hF0, 8'hCC, 1'b0, 2'b00);
    expect_at(1, 8'h3C, 8'h01, "R3 read row 2");
    drain();
    issue(2'b10, 14, 8'hAA, 8'hCC, 1'b0, 2'b01);
    expect_at(0, 8'h3C, 8'h01, "R4 write leaves accumulators");
    drain();
    issue(2'b01, 14, 8'hF0, 8'hCC, 1'b0, 2'b00);
    expect_at(1, 8'h01, 8'h01, "R4 acc1 source written");
    drain();

    // R7: shifts in both directions on both accumulators
    issue(2'b01, 1, 8'hF0, 8'hCC, 1'b0, 2'b00);
    drain();
    issue(2'b11, 0, 8'hAA, 8'hCC, 1'b0, 2'b00);
    expect_at(0, 8'h6A, 8'h01, "R7 acc0 from lower neighbour");
    issue(2'b11, 0, 8'hAA, 8'hCC, 1'b0, 2'b10);
    expect_at(0, 8'h35, 8'h01, "R7 acc0 from upper neighbour");
    issue(2'b11, 0, 8'hAA, 8'hCC, 1'b0, 2'b01);
    expect_at(0, 8'h35, 8'h02, "R7 acc1 from lower neighbour");
    issue(2'b11, 0, 8'hAA, 8'hCC, 1'b0, 2'b11);
    expect_at(0, 8'h35, 8'h01, "R7 acc1 from upper neighbour");
    drain();

    // R10: four-bit add across eight elements
    xs = '{4'd0, 4'd1, 4'd7, 4'd15, 4'd9, 4'd3, 4'd8, 4'd15};
    ys = '{4'd0, 4'd1, 4'd8, 4'd1, 4'd6, 4'd13, 4'd8, 4'd15};
    for (int i = 0; i < NP; i++) begin
      logic [NB:0] s;
      s = {1'b0, xs[i]} + {1'b0, ys[i]};
      cout[i] = s[NB];
      for (int j = 0; j < NB; j++) begin
        xr[j][i] = xs[i][j];
        yr[j][i] = ys[i][j];
        zr[j][i] = s[j];
      end
    end
    make_marker();
    for (int j = 0; j < NB; j++) begin
      load_row(j, xr[j]);
      load_row(NB + j, yr[j]);
    end
    issue(2'b00, 0, 8'hAA, 8'h00, 1'b0, 2'b00);
    for (int j = 0; j < NB; j++) begin
      issue(2'b01, j, 8'hF0, 8'hCC, 1'b0, 2'b00);
      if (j == 0) start_edge = last_edge;
      issue(2'b01, NB + j, 8'h96, 8'hE8, 1'b0, 2'b00);
      issue(2'b10, 2 * NB + j, 8'hAA, 8'hCC, 1'b0, 2'b00);
    end
    expect_at(0, zr[NB-1], cout, "R10 final sum bit and carry out");
    n_chk++;
    if (last_edge - start_edge != 3 * NB - 1) begin
      n_bad++;
      $display("FAIL R10: add length actual %0d edges expected %0d",
               last_edge - start_edge + 1, 3 * NB);
    end
    drain();
    for (int j = 0; j < NB; j++) begin
      issue(2'b01, 2 * NB + j, 8'hF0, 8'hCC, 1'b0, 2'b00);
      expect_at(1, zr[j], cout, $sformatf("R10 sum row bit %0d", j));
      drain();
    end

    // R5/R6: enable mask
    make_marker();
    load_row(12, 8'h00);
    load_row(13, 8'h0F);
    issue(2'b00, 0, 8'hAA, 8'hCC, 1'b0, 2'b10);
    expect_at(0, 8'h0F, 8'h01, "R6 enable load keeps acc0");
    issue(2'b00, 0, 8'hFF, 8'hCC, 1'b0, 2'b00);
    issue(2'b10, 12, 8'hAA, 8'hCC, 1'b0, 2'b00);
    issue(2'b01, 12, 8'hF0, 8'hCC, 1'b0, 2'b00);
    expect_at(1, 8'h0F, 8'h01, "R5 disabled elements keep memory");
    drain();
    issue(2'b00, 0, 8'hFF, 8'hCC, 1'b0, 2'b10);
    issue(2'b10, 12, 8'hAA, 8'hCC, 1'b0, 2'b00);
    issue(2'b01, 12, 8'hF0, 8'hCC, 1'b0, 2'b00);
    expect_at(1, 8'hFF, 8'h01, "R6 enable reloaded to all ones");
    drain();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual run still busy expected finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule